// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Emulator

This block stands in for the device end of a single-wire temperature and humidity sensor. The data line is shared and open-drain. The block sees the line level on one input and can only pull the line low through one output. A host asks for a reading by holding the line low for a long time and then letting it go. After that release, the block answers with a fixed handshake preamble. It then sends a 40-bit frame in which each bit is a device low period followed by a released period, and the length of the released period gives the bit value.

The frame carries four payload bytes and then a checksum byte that the block works out itself. The payload comes in on a 32-bit port and is captured at the moment a response starts, so the port can change during a transmission without corrupting it. Every duration is a parameter counted in clock cycles. The default values assume a 100 MHz clock.

Top module: `rh_sensor_emu`

## Requirements
- R1: After reset, pullLow and busy are both 0.
- R2: A response starts only when the synchronised line has been low for at least MIN_HOST_LOW consecutive cycles and then returns high. A shorter low period is ignored: busy and pullLow stay 0.
- R3: The synchronised release is seen 2 cycles after the line rises, and busy rises 1 cycle after that. The block then keeps the line released for T_WAIT cycles, pulls it low for T_ACK_LOW cycles, and releases it for T_ACK_HIGH cycles.
- R4: Each bit is a pull-low of T_BIT_LOW cycles followed by a release of T_ONE cycles for a 1 or T_ZERO cycles for a 0.
- R5: The 40 bits are sent most significant bit first, in this byte order: payload[31:24], payload[23:16], payload[15:8], payload[7:0], checksum.
- R6: The checksum byte equals the sum of the four payload bytes, truncated to 8 bits.
- R7: After the 40th bit the block pulls the line low once more for T_BIT_LOW cycles. busy falls on the same cycle that this final pull ends.
- R8: The payload is captured when the response starts. Later changes on the payload port do not alter the frame already in progress.
- R9: While busy is high, activity on the line (including a full-length host request) does not start a new response. After busy falls, the block stays idle.
- R10: pullLow is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 1 | Sampled level of the shared data line |
| payload | input | 32 | Humidity integer, humidity fraction, temperature integer, temperature fraction (high byte first) |
| pullLow | output | 1 | 1 = pull the open-drain line low, 0 = release |
| busy | output | 1 | High from start detection until the final release |

## Verification
The hardest case to reach is a full-length host request that arrives in the middle of a transmission. At that point the line is already being toggled by the block itself, and the FSM must leave it alone. The bench forks a second host pulse, longer than MIN_HOST_LOW, while a frame is being measured. It also changes the payload port during the same frame. It then confirms that every pulse width and bit still matches the captured payload, and that no second response follows. To keep the run short, the durations are scaled down to a few cycles. This lets the acceptance boundary be tested at exactly MIN_HOST_LOW and at one cycle less.

// File: rtl/rhemu_pkg.sv
package rhemu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOSTLOW, ST_WAIT, ST_ACKLO, ST_ACKHI, ST_BITLO, ST_BITHI, ST_TAIL
  } rhemuState_t;

  typedef struct packed {
    logic load;   // capture payload and checksum into the frame register
    logic shift;  // advance to next frame bit
  } rhemuStrobe_t;
endpackage

// File: rtl/rhemu_dp.sv
module rhemu_dp
  import rhemu_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  localparam int PW = PAYLOAD_BYTES * 8,
  localparam int FW = PW + 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lineIn,
  input  logic [PW-1:0] payload,
  input  rhemuStrobe_t  strobe,
  output logic          lineSync,
  output logic          curBit
);
  logic syncA;
  logic [FW-1:0] frame;
  logic [7:0] sumByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b1;
      lineSync <= 1'b1;
    end else begin
      syncA    <= lineIn;
      lineSync <= syncA;
    end
  end

  always_comb begin
    sumByte = '0;
    for (int b = 0; b < PAYLOAD_BYTES; b++) sumByte = sumByte + payload[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) frame <= '0;
    else if (strobe.load) frame <= {payload, sumByte};
    else if (strobe.shift) frame <= {frame[FW-2:0], 1'b0};
  end

  assign curBit = frame[FW-1];
endmodule

// File: rtl/rhemu_ctrl.sv
module rhemu_ctrl
  import rhemu_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  parameter int MIN_HOST_LOW  = 1800000,
  parameter int T_WAIT        = 1300,
  parameter int T_ACK_LOW     = 8300,
  parameter int T_ACK_HIGH    = 8700,
  parameter int T_BIT_LOW     = 5400,
  parameter int T_ONE         = 7100,
  parameter int T_ZERO        = 2400,
  localparam int FBITS = (PAYLOAD_BYTES + 1) * 8,
  localparam int BW    = $clog2(FBITS),
  localparam int HW    = $clog2(MIN_HOST_LOW + 1),
  localparam int M1    = (T_WAIT > T_ACK_LOW) ? T_WAIT : T_ACK_LOW,
  localparam int M2    = (T_ACK_HIGH > T_BIT_LOW) ? T_ACK_HIGH : T_BIT_LOW,
  localparam int M3    = (T_ONE > T_ZERO) ? T_ONE : T_ZERO,
  localparam int M12   = (M1 > M2) ? M1 : M2,
  localparam int DMAX  = (M12 > M3) ? M12 : M3,
  localparam int TW    = $clog2(DMAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lineSync,
  input  logic         curBit,
  output rhemuStrobe_t strobe,
  output logic         pullLow,
  output logic         busy
);
  rhemuState_t state;
  logic [TW-1:0] tmr;
  logic [HW-1:0] hostCnt;
  logic [BW-1:0] bitIdx;
  logic tmrDone, hostOk;

  assign tmrDone = (tmr == '0);
  assign hostOk  = (hostCnt >= HW'(MIN_HOST_LOW));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      hostCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!lineSync) begin
          state   <= ST_HOSTLOW;
          hostCnt <= HW'(1);
        end
        ST_HOSTLOW: begin
          if (lineSync) begin
            if (hostOk) begin
              state <= ST_WAIT;
              tmr   <= TW'(T_WAIT - 1);
            end else state <= ST_IDLE;
          end else if (!hostOk) hostCnt <= hostCnt + 1'b1;
        end
        ST_WAIT: if (tmrDone) begin
          state <= ST_ACKLO;
          tmr   <= TW'(T_ACK_LOW - 1);
        end else tmr <= tmr - 1'b1;
        ST_ACKLO: if (tmrDone) begin
          state <= ST_ACKHI;
          tmr   <= TW'(T_ACK_HIGH - 1);
        end else tmr <= tmr - 1'b1;
        ST_ACKHI: if (tmrDone) begin
          state  <= ST_BITLO;
          tmr    <= TW'(T_BIT_LOW - 1);
          bitIdx <= '0;
        end else tmr <= tmr - 1'b1;
        ST_BITLO: if (tmrDone) begin
          state <= ST_BITHI;
          tmr   <= curBit ? TW'(T_ONE - 1) : TW'(T_ZERO - 1);
        end else tmr <= tmr - 1'b1;
        ST_BITHI: if (tmrDone) begin
          tmr <= TW'(T_BIT_LOW - 1);
          if (bitIdx == BW'(FBITS - 1)) state <= ST_TAIL;
          else begin
            state  <= ST_BITLO;
            bitIdx <= bitIdx + 1'b1;
          end
        end else tmr <= tmr - 1'b1;
        ST_TAIL: if (tmrDone) state <= ST_IDLE;
                 else tmr <= tmr - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == ST_HOSTLOW) && lineSync && hostOk;
    strobe.shift = (state == ST_BITHI) && tmrDone;
  end

  assign pullLow = (state == ST_ACKLO) || (state == ST_BITLO) || (state == ST_TAIL);
  assign busy    = (state != ST_IDLE) && (state != ST_HOSTLOW);
endmodule

// File: rtl/rh_sensor_emu.sv
module rh_sensor_emu
  import rhemu_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  parameter int MIN_HOST_LOW  = 1800000,
  parameter int T_WAIT        = 1300,
  parameter int T_ACK_LOW     = 8300,
  parameter int T_ACK_HIGH    = 8700,
  parameter int T_BIT_LOW     = 5400,
  parameter int T_ONE         = 7100,
  parameter int T_ZERO        = 2400
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lineIn,
  input  logic [PAYLOAD_BYTES*8-1:0] payload,
  output logic                       pullLow,
  output logic                       busy
);
  rhemuStrobe_t strobe;
  logic lineSync, curBit;

  rhemu_dp #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_dp (
    .clk(clk), .rst(rst), .lineIn(lineIn), .payload(payload),
    .strobe(strobe), .lineSync(lineSync), .curBit(curBit)
  );

  rhemu_ctrl #(
    .PAYLOAD_BYTES(PAYLOAD_BYTES), .MIN_HOST_LOW(MIN_HOST_LOW), .T_WAIT(T_WAIT),
    .T_ACK_LOW(T_ACK_LOW), .T_ACK_HIGH(T_ACK_HIGH), .T_BIT_LOW(T_BIT_LOW),
    .T_ONE(T_ONE), .T_ZERO(T_ZERO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .lineSync(lineSync), .curBit(curBit),
    .strobe(strobe), .pullLow(pullLow), .busy(busy)
  );
endmodule

// File: rtl/rhemu_checker.sv
module rhemu_checker (
  input logic clk,
  input logic rst,
  input logic lineIn,
  input logic pullLow,
  input logic busy
);
  // R10: the line is only pulled while a response is in progress
  assert_pull_needs_busy_R10: assert property (@(posedge clk) disable iff (rst)
    pullLow |-> busy);

  // R3: a response opens with the line released
  assert_open_released_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !pullLow);

  // R7: the response closes when the final pull ends
  assert_close_after_pull_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(pullLow) && !pullLow));

  // R2: a start follows a line that was high (released) at the synchroniser input
  assert_start_after_release_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(lineIn, 3));

  // R4: a pull never begins in the same cycle a response begins
  assert_pull_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pullLow) |-> $past(busy));
endmodule

bind rh_sensor_emu rhemu_checker u_chk (
  .clk(clk), .rst(rst), .lineIn(lineIn), .pullLow(pullLow), .busy(busy)
);

// File: tb/sim_rh_sensor_emu.sv
`timescale 1ns/1ps
module sim_rh_sensor_emu;
  localparam int MINH = 20, TW = 3, TAL = 8, TAH = 9, TBL = 5, T1 = 7, T0 = 2;

  logic clk = 1'b0, rst = 1'b1, hostLow = 1'b0;
  logic [31:0] payload = '0;
  logic pullLow, busy, lineIn;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign lineIn = !(hostLow || pullLow);

  rh_sensor_emu #(
    .MIN_HOST_LOW(MINH), .T_WAIT(TW), .T_ACK_LOW(TAL), .T_ACK_HIGH(TAH),
    .T_BIT_LOW(TBL), .T_ONE(T1), .T_ZERO(T0)
  ) u0 (.clk(clk), .rst(rst), .lineIn(lineIn), .payload(payload),
        .pullLow(pullLow), .busy(busy));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic measure_run(input logic v, output int len);
    len = 0;
    while (pullLow === v && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic host_pulse(input int n);
    hostLow = 1'b1;
    repeat (n) @(negedge clk);
    hostLow = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pullLow === 1'b0, "R1 pullLow", pullLow, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic t_short_pulse;
    int seen = 0;
    host_pulse(MINH - 1);
    repeat (60) begin
      @(negedge clk);
      if (busy || pullLow) seen++;
    end
    check(seen == 0, "R2 short host pulse ignored", seen, 0);
  endtask

  task automatic t_frame(input logic [31:0] pl, input bit changeMid, input bit hostMid);
    logic [7:0] sum;
    logic [39:0] got;
    int n, busyAt, len, badLow, badHigh, seen;
    sum = pl[31:24] + pl[23:16] + pl[15:8] + pl[7:0];
    payload = pl;
    got = '0; badLow = 0; badHigh = 0; busyAt = 0;
    host_pulse(MINH);
    n = 0;
    while (!pullLow && n < 200) begin
      @(negedge clk);
      n++;
      if (busy && busyAt == 0) busyAt = n;
    end
    check(n == 3 + TW, "R3 release-to-ack latency", n, 3 + TW);
    check(busyAt == 3, "R3 busy rise cycle", busyAt, 3);
    if (changeMid) payload = ~pl;
    fork
      begin
        if (hostMid) begin
          repeat (30) @(negedge clk);
          host_pulse(MINH + 5);
        end
      end
      begin
        measure_run(1'b1, len);
        check(len == TAL, "R3 ack low width", len, TAL);
        measure_run(1'b0, len);
        check(len == TAH, "R3 ack high width", len, TAH);
        for (int i = 0; i < 40; i++) begin
          measure_run(1'b1, len);
          if (len != TBL) badLow++;
          measure_run(1'b0, len);
          if (len != T1 && len != T0) badHigh++;
          got[39-i] = (len == T1);
        end
        check(badLow == 0, "R4 bit low widths", badLow, 0);
        check(badHigh == 0, "R4 bit high widths", badHigh, 0);
        measure_run(1'b1, len);
        check(len == TBL, "R7 tail low width", len, TBL);
        check(busy === 1'b0, "R7 busy falls with final release", busy, 0);
      end
    join
    check(got[39:8] == pl, "R5 R8 payload bits in order", got[39:8], pl);
    check(got[7:0] == sum, "R6 checksum byte", got[7:0], sum);
    seen = 0;
    repeat (80) begin
      @(negedge clk);
      if (busy || pullLow) seen++;
    end
    check(seen == 0, "R9 idle after frame", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_short_pulse();
    t_frame(32'h3A05_1B80, 1'b0, 1'b0);
    t_frame(32'hFFFF_FFFF, 1'b0, 1'b0);   // checksum wraps (R6)
    t_frame(32'h0000_0000, 1'b0, 1'b0);
    t_frame(32'h5C00_2109, 1'b1, 1'b1);   // payload change and host pulse mid-frame (R8, R9)
    t_short_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule